// File: doc/BRIEF.md
# Delta-Sigma Modulator Clock and Bitstream Capture

This block drives an external single-bit, second-order delta-sigma modulator that runs from a clock supplied to it. It divides the system clock into a square-wave modulator clock. The division is set by a half-period count. The modulator produces one output bit for every two cycles of that clock, so the block captures the returning data line only on every second falling edge of the clock it generates.

The data line is asynchronous to the system clock. Its density of ones follows the analog input, and it has no fixed frequency or duty cycle. The block passes it through a two-flop synchronizer. On each capturing edge it presents the synchronized bit together with a one-cycle valid strobe. A downstream decimation filter consumes this pair. Two static outputs drive the modulator's mode-select pins high, which selects the external clock over its internal oscillator.

Top module: `dsm_bitstream_if`

## Requirements
- R1: Both bits of `mode_sel` are 1 at all times, including during reset.
- R2: Let H be the effective half-period. `mod_clk` is low after reset and toggles after every H system-clock cycles. Its high and low phases are therefore equal, and its period is 2H cycles.
- R3: A `half_div` value of 0 is treated as H = 1. Any other value v gives H = v.
- R4: `bit_valid` rises on the same system-clock edge as every second falling edge of `mod_clk`, counting falls from reset: the 2nd, 4th, 6th and so on. `mod_clk` is low in every cycle in which `bit_valid` is high.
- R5: `bit_valid` is high for exactly one system-clock cycle per capture, which gives one strobe every 4H cycles.
- R6: On each strobe, `bit_out` equals the value of `mod_data` that was present two system-clock edges before the capturing edge. `bit_out` holds that value until the next strobe.
- R7: After reset is released, no strobe occurs before cycle 4H. The first strobe comes exactly 4H system-clock edges after release.
- R8: While `rst_n` is low, `mod_clk`, `bit_valid` and `bit_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | Half-period of the modulator clock in system cycles (0 acts as 1); static while running |
| mod_data | input | 1 | Asynchronous serial bit stream returned by the modulator |
| mod_clk | output | 1 | Generated modulator clock, 50% duty |
| mode_sel | output | 2 | Static mode-select drive to the modulator, both bits high |
| bit_out | output | 1 | Most recently captured modulator bit |
| bit_valid | output | 1 | One-cycle strobe marking a new captured bit |

## Verification
The generated clock's falling edge and the capture strobe land on the same system-clock edge on every second fall. A design that delays the strobe or picks the wrong fall would therefore show `bit_valid` beside a high `mod_clk`, or at an odd multiple of 2H. The bench predicts the expected clock level from the cycle count since reset and checks it in every cycle. It checks the strobe in the same cycle, for several half-periods, including the smallest setting, where each fall is only two cycles from the next. A reset in the middle of a run confirms that the first strobe again waits a full 4H cycles.

// File: rtl/dsm_if_pkg.sv
package dsm_if_pkg;

    // default width of the half-period configuration
    parameter int unsigned DEF_DIV_W = 8;
    // default synchronizer depth
    parameter int unsigned DEF_SYNC_STAGES = 2;

    // capture-side state: falling-edge phase, strobe and held bit
    typedef struct packed {
        logic phase;
        logic valid;
        logic bit_val;
    } cap_state_t;

endpackage

// File: rtl/dsm_clk_div.sv
module dsm_clk_div #(
    parameter int unsigned DIV_W = dsm_if_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    output logic             mclk,
    output logic             fall_next
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [DIV_W-1:0] eff_half;
    logic             wrap;

    always_comb begin
        eff_half  = (half_div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : half_div;
        wrap      = (st_q.cnt >= eff_half - 1'b1);
        fall_next = wrap & st_q.lvl;
        st_d      = st_q;
        if (wrap) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mclk = st_q.lvl;

    // R2: the phase counter never leaves the configured half-period
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < eff_half);

endmodule

// File: rtl/dsm_sync.sv
module dsm_sync #(
    parameter int unsigned STAGES = dsm_if_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sr_d, sr_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign sr_d[i] = din;
        end else begin : g_next
            assign sr_d[i] = sr_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[STAGES-1];

endmodule

// File: rtl/dsm_capture.sv
module dsm_capture
    import dsm_if_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall_next,
    input  logic sync_bit,
    input  logic mclk,
    output logic bit_out,
    output logic bit_valid
);

    cap_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (fall_next) begin
            st_d.phase = ~st_q.phase;
            if (st_q.phase) begin
                st_d.valid   = 1'b1;
                st_d.bit_val = sync_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_out   = st_q.bit_val;
    assign bit_valid = st_q.valid;

    // R4: a strobe only appears while the generated clock has just fallen
    assert_strobe_clk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> !mclk);

    // R5: the strobe lasts a single cycle
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // R6: the delivered bit changes only together with a strobe
    assert_bit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> $stable(bit_out));

endmodule

// File: rtl/dsm_bitstream_if.sv
module dsm_bitstream_if #(
    parameter int unsigned DIV_W       = dsm_if_pkg::DEF_DIV_W,
    parameter int unsigned SYNC_STAGES = dsm_if_pkg::DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             mod_data,
    output logic             mod_clk,
    output logic [1:0]       mode_sel,
    output logic             bit_out,
    output logic             bit_valid
);

    logic fall_next;
    logic sync_bit;

    // R1: external-clock mode selected by driving both pins high
    assign mode_sel = 2'b11;

    dsm_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_div  (half_div),
        .mclk      (mod_clk),
        .fall_next (fall_next)
    );

    dsm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mod_data),
        .dout  (sync_bit)
    );

    dsm_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_next (fall_next),
        .sync_bit  (sync_bit),
        .mclk      (mod_clk),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

endmodule

// File: tb/dsm_bitstream_if_test.sv
module dsm_bitstream_if_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] half_div = 8'd1;
    logic       mod_data = 1'b0;
    logic       mod_clk;
    logic [1:0] mode_sel;
    logic       bit_out;
    logic       bit_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    dsm_bitstream_if uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_div  (half_div),
        .mod_data  (mod_data),
        .mod_clk   (mod_clk),
        .mode_sel  (mode_sel),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    // each entry: {half_div setting, 8 data bits sent LSB first}
    localparam logic [15:0] VEC [5] = '{
        {8'd1, 8'hA5}, {8'd2, 8'h3C}, {8'd3, 8'hF0}, {8'd5, 8'h96}, {8'd0, 8'h5A}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic reset_with(input logic [7:0] h, input logic first_bit);
        @(negedge clk);
        rst_n    = 1'b0;
        half_div = h;
        mod_data = first_bit;
        @(negedge clk);
        chk("R8 mod_clk in reset", int'(mod_clk), 0);
        chk("R8 bit_valid in reset", int'(bit_valid), 0);
        chk("R8 bit_out in reset", int'(bit_out), 0);
        chk("R1 mode_sel in reset", int'(mode_sel), 3);
        rst_n = 1'b1;
    endtask

    // run after release; n counts posedges since release
    task automatic run_pattern(input logic [7:0] h, input logic [7:0] pat);
        int eh;
        int per;
        eh  = (h == 0) ? 1 : int'(h);   // R3
        per = 4 * eh;
        for (int n = 1; n <= 8 * per; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R2 mod_clk level", int'(mod_clk), (n / eh) % 2);
            chk("R4 R5 R7 strobe timing", int'(bit_valid), (n % per == 0) ? 1 : 0);
            chk("R1 mode_sel", int'(mode_sel), 3);
            if (n >= per)
                chk("R6 captured bit", int'(bit_out), int'(pat[(n / per) - 1]));
            if (n % per == 0 && (n / per) < 8)
                mod_data = pat[n / per];
        end
    endtask

    initial begin
        for (int v = 0; v < 5; v++) begin
            reset_with(VEC[v][15:8], VEC[v][0]);
            run_pattern(VEC[v][15:8], VEC[v][7:0]);
        end

        // mid-run reset: outputs clear, first strobe waits a full 4H again (R7, R8)
        reset_with(8'd2, 1'b1);
        for (int n = 1; n <= 11; n++) begin
            @(posedge clk);
            @(negedge clk);
        end
        rst_n = 1'b0;
        #1;
        chk("R8 async clear mod_clk", int'(mod_clk), 0);
        chk("R8 async clear bit_out", int'(bit_out), 0);
        chk("R8 async clear bit_valid", int'(bit_valid), 0);
        reset_with(8'd2, 1'b1);
        for (int n = 1; n <= 8; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R7 no early strobe after reset", int'(bit_valid), (n == 8) ? 1 : 0);
        end
        chk("R6 first bit after re-reset", int'(bit_out), 1);

        // H = 0 behaves as H = 1: clock toggles every cycle (R3)
        reset_with(8'd0, 1'b0);
        for (int n = 1; n <= 4; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R3 zero half-period acts as one", int'(mod_clk), n % 2);
        end

        finish_run();
    end

endmodule